// File: doc/BRIEF.md
# Diagnostic Serial Readout Slave

This block lets a host controller read a latched fault word over a four-wire serial link and write a command word in the same frame. All of its logic runs on a fast system clock. The chip select, serial clock and serial input pins are brought into that domain through synchronizers. The chip select then passes through a counting filter, so that pulses too short to be real frame boundaries are rejected.

When the filtered chip select goes low, the block takes a snapshot of the fault word and drives it on SDO, most significant bit first. Channel 1 occupies the top nibble, so its bits leave first. The output enable is high only while a frame is open, so the pad can float the line between frames. The host samples SDO on the falling serial clock edge, and the block advances to the next bit on the rising edge after it. SDI is sampled on the falling edge into a receive register, which is presented in parallel when the frame closes. A frame with exactly the nominal number of falling clock edges returns a one-cycle clear request to the fault latches. Any other frame length returns none.

Top module: `diag_spi_slave`

## Requirements
- R1: After reset, `sdo_oe`, `sdo`, `rx_valid` and `clr_req` are 0 and `rx_word` is all zeros.
- R2: `sdo_oe` is 1 only while a frame is open: it rises within a few system cycles after `cs_n_pad` has been low for `FILT_CYC` cycles, and falls after `cs_n_pad` has been high for `FILT_CYC` cycles. While `sdo_oe` is 0, `sdo` is 0.
- R3: A level change on `cs_n_pad` lasting fewer than `FILT_CYC` system cycles is ignored. An idle-time low glitch opens no frame. A high glitch inside a frame neither closes it nor restarts it.
- R4: At frame open, `fault_vec` is captured, and its bit 15 (channel 1 in bits 15:12) is on `sdo` before the first serial clock edge. Later changes of `fault_vec` in the same frame have no effect on `sdo`.
- R5: `sdo` advances by one bit only on a rising serial clock edge that follows a falling edge within the frame. It therefore presents captured bit 15-k between rising and falling edge k (counting from 0), and 0 once all bits have gone.
- R6: Each falling serial clock edge in a frame shifts SDI into the receive register at bit 0, moving earlier bits up. At frame close, `rx_word` takes that register (the last 16 bits received, first bit highest) and `rx_valid` pulses for one system cycle. `rx_word` changes at no other time.
- R7: At frame close, `clr_req` pulses for exactly one system cycle if exactly `FRAME_BITS` (16) falling serial clock edges occurred in the frame. Serial clock edges outside a frame are not counted.
- R8: A frame with fewer or more than `FRAME_BITS` falling serial clock edges produces no `clr_req` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_pad | input | 1 | Active-low chip select from the pad, asynchronous |
| sclk_pad | input | 1 | Serial clock from the pad, idles low |
| sdi_pad | input | 1 | Serial data from the host |
| fault_vec | input | FRAME_BITS | Latched fault word from the fault logic |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the SDO pad driver |
| rx_word | output | FRAME_BITS | Last received command word |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |
| clr_req | output | 1 | One-cycle request to clear the fault latches |

## Verification
The bound checker watches, on every cycle, the invariants that relate the outputs to each other. The clear and update pulses last one cycle. A clear only comes with a word update. A word update only comes with the frame closing. `rx_word` only changes at an update, and `sdo` is quiet whenever the driver is disabled. Only the bench scenarios can show the serial behaviour: the order of the bits shifted out, the snapshot isolation from later fault changes, rejection of chip-select glitches, the content of the received word, and the decision whether to clear for short, exact and long frames.

// File: rtl/diag_spi_pkg.sv
package diag_spi_pkg;

    // Serial clock event seen in the system clock domain
    typedef enum logic [1:0] {
        SCK_NONE = 2'd0,
        SCK_RISE = 2'd1,
        SCK_FALL = 2'd2
    } sck_evt_e;

    // Chip-select filter event
    typedef enum logic [1:0] {
        CSF_NONE  = 2'd0,
        CSF_OPEN  = 2'd1,
        CSF_CLOSE = 2'd2
    } csf_evt_e;

endpackage

// File: rtl/diag_sync.sv
module diag_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    // Next value of each flop: first stage takes the pad, later ones the previous stage
    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            if (i == 0) stage_d[i] = async_in;
            else        stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= stage_d[i];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/diag_cs_filter.sv
module diag_cs_filter
    import diag_spi_pkg::*;
#(
    parameter int FILT_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cs_n_s,
    output logic     cs_n_filt,
    output csf_evt_e evt
);

    localparam int CNT_W = $clog2(FILT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);

    typedef struct packed {
        logic             level;
        logic [CNT_W-1:0] cnt;
        csf_evt_e         evt;
    } filt_t;

    filt_t st_d, st_q;

    // A differing input level must persist FILT_CYC cycles before it is taken
    always_comb begin
        st_d     = st_q;
        st_d.evt = CSF_NONE;
        if (cs_n_s != st_q.level) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.level = cs_n_s;
                st_d.cnt   = '0;
                st_d.evt   = cs_n_s ? CSF_CLOSE : CSF_OPEN;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.level <= 1'b1;
            st_q.cnt   <= '0;
            st_q.evt   <= CSF_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n_filt = st_q.level;
    assign evt       = st_q.evt;

endmodule

// File: rtl/diag_sck_edge.sv
module diag_sck_edge
    import diag_spi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sck_s,
    output sck_evt_e evt
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sck_s;
        if (sck_s && !prev_q)      evt = SCK_RISE;
        else if (!sck_s && prev_q) evt = SCK_FALL;
        else                       evt = SCK_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/diag_shift_engine.sv
module diag_shift_engine
    import diag_spi_pkg::*;
#(
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  csf_evt_e              cs_evt,
    input  sck_evt_e              sck_evt,
    input  logic                  sdi_s,
    input  logic [FRAME_BITS-1:0] snap_in,
    output logic                  sdo_bit,
    output logic                  sdo_en,
    output logic [FRAME_BITS-1:0] rx_out,
    output logic                  rx_pulse,
    output logic                  clr_pulse
);

    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_SAT   = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_EXACT = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic                  active;   // frame open
        logic                  armed;    // falling edge seen since last shift out
        logic [FRAME_BITS-1:0] tx;
        logic [FRAME_BITS-1:0] rx;
        logic [CNT_W-1:0]      falls;    // saturating count of falling edges
        logic [FRAME_BITS-1:0] rx_word;
        logic                  rx_pulse;
        logic                  clr;
    } eng_t;

    eng_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.rx_pulse = 1'b0;
        st_d.clr      = 1'b0;
        if (cs_evt == CSF_OPEN) begin
            // frame start: snapshot the fault word, clear the shift state
            st_d.active = 1'b1;
            st_d.armed  = 1'b0;
            st_d.tx     = snap_in;
            st_d.rx     = '0;
            st_d.falls  = '0;
        end else if (cs_evt == CSF_CLOSE && st_q.active) begin
            // frame end: publish received word, decide on clear
            st_d.active   = 1'b0;
            st_d.armed    = 1'b0;
            st_d.rx_word  = st_q.rx;
            st_d.rx_pulse = 1'b1;
            st_d.clr      = (st_q.falls == CNT_EXACT);
        end else if (st_q.active) begin
            unique case (sck_evt)
                SCK_RISE: begin
                    // advance output only after the host has sampled it
                    if (st_q.armed) begin
                        st_d.tx    = {st_q.tx[FRAME_BITS-2:0], 1'b0};
                        st_d.armed = 1'b0;
                    end
                end
                SCK_FALL: begin
                    st_d.rx    = {st_q.rx[FRAME_BITS-2:0], sdi_s};
                    st_d.armed = 1'b1;
                    if (st_q.falls != CNT_SAT) st_d.falls = st_q.falls + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_bit   = st_q.active & st_q.tx[FRAME_BITS-1];
    assign sdo_en    = st_q.active;
    assign rx_out    = st_q.rx_word;
    assign rx_pulse  = st_q.rx_pulse;
    assign clr_pulse = st_q.clr;

endmodule

// File: rtl/diag_spi_slave.sv
module diag_spi_slave
    import diag_spi_pkg::*;
#(
    parameter int FRAME_BITS  = 16,
    parameter int FILT_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n_pad,
    input  logic                  sclk_pad,
    input  logic                  sdi_pad,
    input  logic [FRAME_BITS-1:0] fault_vec,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  rx_valid,
    output logic                  clr_req
);

    // pin order in the synchronized bundle
    localparam int IDX_CS  = 2;
    localparam int IDX_SCK = 1;
    localparam int IDX_SDI = 0;
    localparam logic [2:0] PIN_RST = 3'b100;

    logic [2:0] pins_s;
    logic       cs_n_filt;
    csf_evt_e   cs_evt;
    sck_evt_e   sck_evt;

    diag_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n_pad, sclk_pad, sdi_pad}),
        .sync_out (pins_s)
    );

    diag_cs_filter #(
        .FILT_CYC (FILT_CYC)
    ) u_csf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (pins_s[IDX_CS]),
        .cs_n_filt (cs_n_filt),
        .evt       (cs_evt)
    );

    diag_sck_edge u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .sck_s (pins_s[IDX_SCK]),
        .evt   (sck_evt)
    );

    diag_shift_engine #(
        .FRAME_BITS (FRAME_BITS)
    ) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_evt    (cs_evt),
        .sck_evt   (sck_evt),
        .sdi_s     (pins_s[IDX_SDI]),
        .snap_in   (fault_vec),
        .sdo_bit   (sdo),
        .sdo_en    (sdo_oe),
        .rx_out    (rx_word),
        .rx_pulse  (rx_valid),
        .clr_pulse (clr_req)
    );

    // filtered level is carried in the event stream; kept for readability of waves
    logic unused_filt;
    assign unused_filt = cs_n_filt;

endmodule

// File: rtl/diag_spi_checker.sv
module diag_spi_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sdo,
    input logic         sdo_oe,
    input logic [W-1:0] rx_word,
    input logic         rx_valid,
    input logic         clr_req
);

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !clr_req); // R7

    AST_CLR_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |-> rx_valid); // R7

    AST_RXV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6

    AST_RXV_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $fell(sdo_oe)); // R6

    AST_RXW_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_word) |-> rx_valid); // R6

    AST_SDO_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo); // R2

endmodule

bind diag_spi_slave diag_spi_checker #(.W(FRAME_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .rx_word  (rx_word),
    .rx_valid (rx_valid),
    .clr_req  (clr_req)
);

// File: tb/sim_diag_spi_slave.sv
module sim_diag_spi_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n_pad = 1'b1;
    logic        sclk_pad = 1'b0;
    logic        sdi_pad = 1'b0;
    logic [15:0] fault_vec = '0;
    logic        sdo, sdo_oe, rx_valid, clr_req;
    logic [15:0] rx_word;

    int n_checks = 0;
    int n_fails  = 0;
    int clr_hi   = 0;
    int rxv_hi   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    diag_spi_slave u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_pad  (cs_n_pad),
        .sclk_pad  (sclk_pad),
        .sdi_pad   (sdi_pad),
        .fault_vec (fault_vec),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid),
        .clr_req   (clr_req)
    );

    // pulse-length monitor: total high cycles of each pulse output
    always @(negedge clk) begin
        if (rst_n && clr_req)  clr_hi++;
        if (rst_n && rx_valid) rxv_hi++;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] shift_in(input logic [15:0] r, input logic b);
        return {r[14:0], b};
    endfunction

    function automatic logic exp_sdo(input logic [15:0] snap, input int k);
        return (k < 16) ? snap[15-k] : 1'b0;
    endfunction

    task automatic run_frame(input logic [15:0] fault, input int nbits, input bit glitch_mid);
        logic [15:0] exp_rx = '0;
        logic        b;
        int          clr0 = clr_hi;
        int          rxv0 = rxv_hi;
        fault_vec = fault;
        cs_n_pad  = 1'b0;
        wait_clk(12);
        check(sdo_oe == 1'b1, "R2 open", 32'(sdo_oe), 1);
        check(sdo == fault[15], "R4 first bit", 32'(sdo), 32'(fault[15]));
        fault_vec = 16'($urandom);   // must not reach sdo
        for (int k = 0; k < nbits; k++) begin
            b       = 1'($urandom_range(0, 1));
            exp_rx  = shift_in(exp_rx, b);
            sdi_pad = b;
            wait_clk(4);
            sclk_pad = 1'b1;
            wait_clk(8);
            check(sdo == exp_sdo(fault, k), "R5 R4 bit order", 32'(sdo), 32'(exp_sdo(fault, k)));
            if (glitch_mid && k == 5) begin
                cs_n_pad = 1'b1;   // R3 high glitch inside frame
                wait_clk(2);
                cs_n_pad = 1'b0;
                wait_clk(2);
            end
            sclk_pad = 1'b0;
            wait_clk(4);
        end
        wait_clk(4);
        cs_n_pad = 1'b1;
        wait_clk(12);
        check(sdo_oe == 1'b0, "R2 close", 32'(sdo_oe), 0);
        check(rx_word == exp_rx, "R6 rx_word", 32'(rx_word), 32'(exp_rx));
        check(rxv_hi - rxv0 == 1, "R6 rx_valid pulse", 32'(rxv_hi - rxv0), 1);
        if (nbits == 16)
            check(clr_hi - clr0 == 1, "R7 clear on exact frame", 32'(clr_hi - clr0), 1);
        else
            check(clr_hi - clr0 == 0, "R8 no clear on wrong length", 32'(clr_hi - clr0), 0);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        int rxv0;
        logic [15:0] held;
        bit seen_oe;
        void'($urandom(32'd2718));
        wait_clk(3);
        // R1 reset state
        check(sdo_oe == 1'b0 && sdo == 1'b0, "R1 sdo idle", 32'({sdo_oe, sdo}), 0);
        check(rx_valid == 1'b0 && clr_req == 1'b0, "R1 pulses low", 32'({rx_valid, clr_req}), 0);
        check(rx_word == 16'h0, "R1 rx_word", 32'(rx_word), 0);
        rst_n = 1'b1;
        wait_clk(5);
        check(sdo_oe == 1'b0, "R1 after release", 32'(sdo_oe), 0);

        // directed corner patterns
        run_frame(16'h8000, 16, 1'b0);
        run_frame(16'hA5C3, 16, 1'b0);
        run_frame(16'hFFFF, 8, 1'b0);    // R8 short
        run_frame(16'h1234, 20, 1'b0);   // R8 long
        run_frame(16'h0F0F, 16, 1'b1);   // R3 glitch inside frame

        // R3 low glitch while idle opens no frame
        rxv0    = rxv_hi;
        held    = rx_word;
        seen_oe = 1'b0;
        cs_n_pad = 1'b0;
        wait_clk(2);
        cs_n_pad = 1'b1;
        for (int i = 0; i < 20; i++) begin
            wait_clk(1);
            if (sdo_oe) seen_oe = 1'b1;
        end
        check(seen_oe == 1'b0, "R3 idle glitch no oe", 32'(seen_oe), 0);
        check(rxv_hi == rxv0 && rx_word == held, "R3 idle glitch no frame", 32'(rxv_hi - rxv0), 0);

        // R7 serial clock toggles outside a frame are not counted
        for (int i = 0; i < 5; i++) begin
            sclk_pad = 1'b1; wait_clk(8);
            sclk_pad = 1'b0; wait_clk(8);
        end
        run_frame(16'h5AA5, 16, 1'b0);

        // constrained random frames, lengths around the nominal one
        for (int f = 0; f < 12; f++) begin
            int len;
            len = (f % 3 == 0) ? 16 : int'($urandom_range(12, 20));
            run_frame(16'($urandom), len, 1'b0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

endmodule